// File: doc/BRIEF.md
# Machine-Cycle Reset Sequencer

This block produces the internal reset of a small processor core whose machine cycle has four clock states, C1 to C4. It runs a free-running state counter and samples the external reset pin once per machine cycle. It accepts a one-clock watchdog-timeout pulse and a level from the supply monitor, which is high while the supply is below its threshold. From these it decides when the core is held in reset and when it may run. All reset handling is synchronous to `clk`, so the clock must be running for any source to act. While reset is active the core fetch address is the constant `boot_addr`, so execution always starts at address 0000h.

The control path is an FSM with five states:
- `S_POR` counts the power-on delay.
- `S_RUN` is normal execution.
- `S_EXT` holds reset while the pin is still sampled high.
- `S_STRETCH` keeps reset asserted for a fixed number of machine cycles after the pin is released.
- `S_WDT` holds reset after a watchdog timeout.

The transitions are:
- POR_DONE (`S_POR`→`S_RUN`) fires after `POR_MC` machine cycles.
- PIN_VALID goes from `S_RUN`, `S_STRETCH` or `S_WDT` to `S_EXT` after two consecutive high C4 samples.
- PIN_LOW (`S_EXT`→`S_STRETCH`) fires on the first low sample.
- STRETCH_DONE (`S_STRETCH`→`S_RUN`) fires after `STRETCH_MC` machine cycles.
- WDT_HIT (`S_RUN`→`S_WDT`) fires on a timeout pulse.
- WDT_DONE (`S_WDT`→`S_RUN`) fires after `WDT_MC` machine cycles.
- SUPPLY_LOW forces `S_POR` from any state.

Two software-visible flags record the cause of reset, and each has its own clear strobe. An external reset leaves both flags alone. Software infers an external reset when both flags read clear.

Top module: `rst_seq_top`

## Requirements
- R1: `mc_state` encodes C1..C4 as 0..3 and advances by one each clock, wrapping from 3 to 0. It is forced to 0 while `supply_low` is high.
- R2: While `supply_low` is high, `sys_rst` is 1 and both flags are 0. After `supply_low` falls, `sys_rst` stays 1 for exactly 4·`POR_MC` clocks. `por_flag` becomes 1 on the same edge at which `sys_rst` falls.
- R3: `rst_pin` is observed only on the clock edge that ends state C4 (`mc_state`=3). A pin that is high in C1..C3 but low in C4 never causes reset.
- R4: A single isolated high C4 sample, or alternating samples, never causes reset.
- R5: After two consecutive high C4 samples, `sys_rst` rises one clock after the edge of the second sample. It stays high while samples remain high. It falls exactly 2 machine cycles (8 clocks) after the edge of the first low sample, with `mc_state`=0.
- R6: An external reset changes neither `por_flag` nor `wdt_flag`. After `por_flag` is cleared, an external reset leaves both flags at 0.
- R7: A `wdt_timeout` pulse during normal running sets `wdt_flag` and asserts `sys_rst` on the next edge. Reset is released at the second C4 boundary after that edge. This is 8 clocks when the pulse is sampled at the end of C4, and 5 clocks when it is sampled at the end of C3.
- R8: A `wdt_timeout` pulse while `sys_rst` is asserted has no effect.
- R9: `clr_por_flag` and `clr_wdt_flag` clear their flag on the next edge. `wdt_flag` survives external and watchdog resets and is cleared only by its strobe or by a power-on reset.
- R10: `boot_addr` is 0000h in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock; one period is one machine-cycle state |
| supply_low | input | 1 | supply monitor, high while the supply is below threshold; synchronous power-on reset |
| rst_pin | input | 1 | external reset pin, active high |
| wdt_timeout | input | 1 | one-clock watchdog-timeout pulse |
| clr_por_flag | input | 1 | software strobe that clears `por_flag` |
| clr_wdt_flag | input | 1 | software strobe that clears `wdt_flag` |
| sys_rst | output | 1 | internal reset, active high |
| boot_addr | output | 16 | reset vector (0000h) |
| mc_state | output | 2 | machine-cycle state, 0..3 for C1..C4 |
| por_flag | output | 1 | power-on reset cause flag |
| wdt_flag | output | 1 | watchdog reset cause flag |

## Verification
The pin path is driven with whole-machine-cycle patterns, and the clocks of reset seen for each pattern are counted:
- Patterns with no reset: all low, one isolated high, alternating highs.
- Patterns with one pulse: runs of two, three and four highs, which separate the hold time from the fixed stretch.
- A pair that follows an isolated high.
- Two separate pairs, which show that a second valid pair after a completed stretch re-enters reset.

A pin that is high everywhere except C4 separates C4-only sampling from any other sampling phase. Watchdog pulses at two phases separate machine-cycle-aligned release from a fixed clock count. Flag sequences tell external, watchdog and power-on causes apart.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [2:0] {
        S_POR     = 3'd0,
        S_RUN     = 3'd1,
        S_EXT     = 3'd2,
        S_STRETCH = 3'd3,
        S_WDT     = 3'd4
    } rst_state_e;
endpackage

// File: rtl/rst_mc_counter.sv
module rst_mc_counter #(
    parameter int unsigned MC_STATES = 4,
    localparam int unsigned PH_W = $clog2(MC_STATES)
) (
    input  logic            clk,
    input  logic            supply_low,
    output logic [PH_W-1:0] phase,
    output logic            tick
);
    localparam logic [PH_W-1:0] LAST = PH_W'(MC_STATES - 1);

    always_ff @(posedge clk) begin
        if (supply_low)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // high during the final state of a machine cycle
    assign tick = (phase == LAST);
endmodule

// File: rtl/rst_pin_sampler.sv
module rst_pin_sampler #(
    parameter int unsigned SAMPLES = 2
) (
    input  logic clk,
    input  logic supply_low,
    input  logic tick,
    input  logic pin,
    output logic pin_level,
    output logic pin_valid
);
    logic [SAMPLES-1:0] hist;

    always_ff @(posedge clk) begin
        if (supply_low)
            hist <= '0;
        else if (tick)
            hist <= {hist[SAMPLES-2:0], pin};
    end

    assign pin_level = hist[0];
    assign pin_valid = &hist;
endmodule

// File: rtl/rst_ctrl_fsm.sv
module rst_ctrl_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned POR_MC     = 1024,
    parameter int unsigned STRETCH_MC = 2,
    parameter int unsigned WDT_MC     = 2,
    localparam int unsigned CNT_W     = $clog2(POR_MC + 1)
) (
    input  logic clk,
    input  logic supply_low,
    input  logic tick,
    input  logic pin_level,
    input  logic pin_valid,
    input  logic wdt_timeout,
    output logic sys_rst,
    output logic por_set,
    output logic wdt_set
);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_MC - 1);
    localparam logic [CNT_W-1:0] STR_LAST = CNT_W'(STRETCH_MC - 1);
    localparam logic [CNT_W-1:0] WDT_LAST = CNT_W'(WDT_MC - 1);

    rst_state_e       state, nxt;
    logic [CNT_W-1:0] mc_cnt;

    // state register and machine-cycle counter
    always_ff @(posedge clk) begin
        if (supply_low) begin
            state  <= S_POR;
            mc_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                mc_cnt <= '0;
            else if (tick)
                mc_cnt <= mc_cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_POR:     if (tick && mc_cnt == POR_LAST) nxt = S_RUN;
            S_RUN:     if (pin_valid) nxt = S_EXT;
                       else if (wdt_timeout) nxt = S_WDT;
            S_EXT:     if (!pin_level) nxt = S_STRETCH;
            S_STRETCH: if (pin_valid) nxt = S_EXT;
                       else if (tick && mc_cnt == STR_LAST) nxt = S_RUN;
            S_WDT:     if (pin_valid) nxt = S_EXT;
                       else if (tick && mc_cnt == WDT_LAST) nxt = S_RUN;
            default:   nxt = S_POR;
        endcase
    end

    // outputs
    always_comb begin
        sys_rst = (state != S_RUN);
        por_set = (state == S_POR) && (nxt == S_RUN);
        wdt_set = (state == S_RUN) && (nxt == S_WDT);
    end
endmodule

// File: rtl/rst_flags.sv
module rst_flags (
    input  logic clk,
    input  logic supply_low,
    input  logic por_set,
    input  logic wdt_set,
    input  logic clr_por,
    input  logic clr_wdt,
    output logic por_flag,
    output logic wdt_flag
);
    always_ff @(posedge clk) begin
        if (supply_low) begin
            por_flag <= 1'b0;
            wdt_flag <= 1'b0;
        end else begin
            por_flag <= por_set | (por_flag & ~clr_por);
            wdt_flag <= wdt_set | (wdt_flag & ~clr_wdt);
        end
    end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int unsigned MC_STATES   = 4,
    parameter int unsigned PIN_SAMPLES = 2,
    parameter int unsigned POR_MC      = 1024,
    parameter int unsigned STRETCH_MC  = 2,
    parameter int unsigned WDT_MC      = 2,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned RESET_VEC   = 0,
    localparam int unsigned PH_W       = $clog2(MC_STATES)
) (
    input  logic              clk,
    input  logic              supply_low,
    input  logic              rst_pin,
    input  logic              wdt_timeout,
    input  logic              clr_por_flag,
    input  logic              clr_wdt_flag,
    output logic              sys_rst,
    output logic [ADDR_W-1:0] boot_addr,
    output logic [PH_W-1:0]   mc_state,
    output logic              por_flag,
    output logic              wdt_flag
);
    logic tick, pin_level, pin_valid, por_set, wdt_set;

    rst_mc_counter #(.MC_STATES(MC_STATES)) u_mc (
        .clk(clk), .supply_low(supply_low), .phase(mc_state), .tick(tick)
    );

    rst_pin_sampler #(.SAMPLES(PIN_SAMPLES)) u_pin (
        .clk(clk), .supply_low(supply_low), .tick(tick), .pin(rst_pin),
        .pin_level(pin_level), .pin_valid(pin_valid)
    );

    rst_ctrl_fsm #(.POR_MC(POR_MC), .STRETCH_MC(STRETCH_MC), .WDT_MC(WDT_MC)) u_fsm (
        .clk(clk), .supply_low(supply_low), .tick(tick), .pin_level(pin_level),
        .pin_valid(pin_valid), .wdt_timeout(wdt_timeout), .sys_rst(sys_rst),
        .por_set(por_set), .wdt_set(wdt_set)
    );

    rst_flags u_flags (
        .clk(clk), .supply_low(supply_low), .por_set(por_set), .wdt_set(wdt_set),
        .clr_por(clr_por_flag), .clr_wdt(clr_wdt_flag),
        .por_flag(por_flag), .wdt_flag(wdt_flag)
    );

    assign boot_addr = ADDR_W'(RESET_VEC);
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int unsigned MC_STATES = 4,
    localparam int unsigned PH_W     = $clog2(MC_STATES)
) (
    input logic            clk,
    input logic            supply_low,
    input logic            sys_rst,
    input logic [PH_W-1:0] mc_state,
    input logic            por_flag,
    input logic            wdt_flag,
    input logic            clr_wdt_flag
);
    localparam logic [PH_W-1:0] LAST = PH_W'(MC_STATES - 1);

    p_supply_hold_r2: assert property (@(posedge clk)
        supply_low |=> (sys_rst && !por_flag && !wdt_flag));

    p_phase_step_r1: assert property (@(posedge clk) disable iff (supply_low)
        1'b1 |=> (mc_state == (($past(mc_state) == LAST) ? '0 : $past(mc_state) + 1'b1)));

    p_release_c1_r5: assert property (@(posedge clk) disable iff (supply_low)
        $fell(sys_rst) |-> (mc_state == '0));

    p_por_flag_r2: assert property (@(posedge clk) disable iff (supply_low)
        $rose(por_flag) |-> $fell(sys_rst));

    p_wdt_entry_r7: assert property (@(posedge clk) disable iff (supply_low)
        $rose(wdt_flag) |-> (sys_rst && $past(!sys_rst)));

    p_wdt_keep_r9: assert property (@(posedge clk) disable iff (supply_low)
        (wdt_flag && !clr_wdt_flag) |=> wdt_flag);
endmodule

bind rst_seq_top rst_seq_chk #(.MC_STATES(MC_STATES)) u_chk (
    .clk(clk), .supply_low(supply_low), .sys_rst(sys_rst), .mc_state(mc_state),
    .por_flag(por_flag), .wdt_flag(wdt_flag), .clr_wdt_flag(clr_wdt_flag)
);

// File: tb/tb_rst_seq_top.sv
`timescale 1ns/1ps
module tb_rst_seq_top;
    localparam int POR_MC = 1024;

    logic        clk = 1'b0;
    logic        supply_low = 1'b1;
    logic        rst_pin = 1'b0;
    logic        wdt_timeout = 1'b0;
    logic        clr_por_flag = 1'b0;
    logic        clr_wdt_flag = 1'b0;
    logic        sys_rst;
    logic [15:0] boot_addr;
    logic [1:0]  mc_state;
    logic        por_flag, wdt_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_seq_top dut (
        .clk(clk), .supply_low(supply_low), .rst_pin(rst_pin), .wdt_timeout(wdt_timeout),
        .clr_por_flag(clr_por_flag), .clr_wdt_flag(clr_wdt_flag), .sys_rst(sys_rst),
        .boot_addr(boot_addr), .mc_state(mc_state), .por_flag(por_flag), .wdt_flag(wdt_flag)
    );

    // {pin pattern (bit0 = first machine cycle), expected reset clocks}
    localparam logic [15:0] VEC [8] = '{
        {8'b00000000, 8'd0},
        {8'b00000001, 8'd0},
        {8'b00000101, 8'd0},
        {8'b00000011, 8'd11},
        {8'b00000111, 8'd15},
        {8'b00011110, 8'd19},
        {8'b00101101, 8'd11},
        {8'b00110011, 8'd22}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic align_c1();
        @(negedge clk);
        while (mc_state != 2'd0) @(negedge clk);
    endtask

    task automatic power_up(output int cnt);
        @(negedge clk);
        supply_low = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!sys_rst) break;
            cnt++;
        end
    endtask

    task automatic ext_pulse(input int mcs);
        align_c1();
        rst_pin = 1'b1;
        repeat (4 * mcs) @(negedge clk);
        rst_pin = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic run_all();
        int cnt;
        // reset state
        repeat (10) @(negedge clk);
        chk("R2 rst during supply low", int'(sys_rst), 1);
        chk("R2 por_flag during supply low", int'(por_flag), 0);
        chk("R2 wdt_flag during supply low", int'(wdt_flag), 0);
        chk("R1 mc_state during supply low", int'(mc_state), 0);
        chk("R10 boot_addr", int'(boot_addr), 0);

        power_up(cnt);
        chk("R2 power-on delay", cnt, 4 * POR_MC - 1);
        chk("R2 por_flag after delay", int'(por_flag), 1);
        chk("R1 mc_state at release", int'(mc_state), 0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R1 mc_state sequence", int'(mc_state), k % 4);
        end

        // table of pin patterns
        for (int v = 0; v < 8; v++) begin
            align_c1();
            cnt = 0;
            for (int m = 0; m < 12; m++) begin
                rst_pin = (m < 8) ? VEC[v][8 + m] : 1'b0;
                repeat (4) begin
                    @(negedge clk);
                    if (sys_rst) cnt++;
                end
            end
            chk($sformatf("R3 R4 R5 pattern %0d reset clocks", v), cnt, int'(VEC[v][7:0]));
            chk("R6 por_flag kept by ext reset", int'(por_flag), 1);
            chk("R6 wdt_flag untouched by ext reset", int'(wdt_flag), 0);
        end

        // R3: high in C1..C3, low in C4
        align_c1();
        cnt = 0;
        for (int m = 0; m < 4; m++) begin
            rst_pin = 1'b1;
            repeat (3) begin @(negedge clk); if (sys_rst) cnt++; end
            rst_pin = 1'b0;
            @(negedge clk); if (sys_rst) cnt++;
        end
        repeat (12) begin @(negedge clk); if (sys_rst) cnt++; end
        chk("R3 pin low at C4 ignored", cnt, 0);

        // R5 entry timing: rises one clock after the second sampling edge
        align_c1();
        rst_pin = 1'b1;
        repeat (8) @(negedge clk);
        chk("R5 no reset at second sample edge", int'(sys_rst), 0);
        @(negedge clk);
        chk("R5 reset one clock after second sample", int'(sys_rst), 1);
        rst_pin = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 released", int'(sys_rst), 0);

        // R7 watchdog sampled at end of C4
        @(negedge clk);
        while (mc_state != 2'd3) @(negedge clk);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        cnt = 0;
        while (sys_rst) begin cnt++; @(negedge clk); end
        chk("R7 wdt reset length (C4 aligned)", cnt, 8);
        chk("R7 wdt_flag set", int'(wdt_flag), 1);
        chk("R7 release in C1", int'(mc_state), 0);

        // R7 watchdog sampled at end of C3
        while (mc_state != 2'd2) @(negedge clk);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        cnt = 0;
        while (sys_rst) begin cnt++; @(negedge clk); end
        chk("R7 wdt reset length (C3 aligned)", cnt, 5);

        // R9 wdt flag survives an external reset
        ext_pulse(3);
        chk("R9 wdt_flag survives ext reset", int'(wdt_flag), 1);

        // R9 clear strobe
        clr_wdt_flag = 1'b1;
        @(negedge clk);
        clr_wdt_flag = 1'b0;
        chk("R9 wdt_flag cleared by strobe", int'(wdt_flag), 0);

        // R8 watchdog ignored during reset
        align_c1();
        rst_pin = 1'b1;
        repeat (12) @(negedge clk);
        chk("R8 in ext reset", int'(sys_rst), 1);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        repeat (4) @(negedge clk);
        rst_pin = 1'b0;
        repeat (24) @(negedge clk);
        chk("R8 wdt_flag stays clear", int'(wdt_flag), 0);
        chk("R8 reset released", int'(sys_rst), 0);
        chk("R6 por_flag kept", int'(por_flag), 1);

        // R9 por clear, R6 external leaves both flags clear
        clr_por_flag = 1'b1;
        @(negedge clk);
        clr_por_flag = 1'b0;
        chk("R9 por_flag cleared by strobe", int'(por_flag), 0);
        ext_pulse(2);
        chk("R6 por_flag after ext reset", int'(por_flag), 0);
        chk("R6 wdt_flag after ext reset", int'(wdt_flag), 0);

        // R9/R2: power drop clears wdt flag, re-sets por flag
        @(negedge clk);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        repeat (12) @(negedge clk);
        chk("R7 wdt_flag before power drop", int'(wdt_flag), 1);
        supply_low = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 reset on supply drop", int'(sys_rst), 1);
        chk("R9 wdt_flag cleared by power-on", int'(wdt_flag), 0);
        power_up(cnt);
        chk("R2 second power-on delay", cnt, 4 * POR_MC - 1);
        chk("R2 por_flag set again", int'(por_flag), 1);
        chk("R9 wdt_flag clear after power-on", int'(wdt_flag), 0);
        chk("R10 boot_addr after run", int'(boot_addr), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule